// File: doc/BRIEF.md
# Bus Hold Arbiter

This block decides who owns the local bus: the processor's own bus-cycle sequencer or an external master that asks for the bus. The external master raises a hold request that may change at any time relative to the processor clock. The block synchronizes that request and grants it only between bus cycles, never in the middle of one. Granting raises the acknowledge output and, on the same clock edge, raises a float enable. The pad logic uses the float enable to put the address, data and bus-control drivers into high impedance. Chip-select outputs are not tied to the float enable, so they keep being driven while the bus is held.

When the request is withdrawn, the acknowledge output falls. The bus stays floated until the core actually asks for a new cycle, and only then does the processor drive it again. A cycle-start permit tells the sequencer when it may begin a bus cycle. The permit is never given while the bus is held away.

Top module: `bus_hold_arb`

## Requirements
- R1: While reset is asserted (active-low, asynchronous) and after it is released, the acknowledge output and the float enable are low and the controller owns the bus.
- R2: The hold request passes through a two-flop synchronizer. The acknowledge output cannot rise before the third rising clock edge after the request goes high, and it rises on that edge if the bus-state input is at a cycle boundary.
- R3: The bus-state input is 3 bits wide, with codes T1=0, T2=1, T3=2, T4=3, idle=4 and wait=5. A grant happens only on an edge where the bus-state is T4 or idle. With T1, T2, T3 or wait, no grant is made.
- R4: The float enable is high in every cycle in which the acknowledge output is high, and it rises on the same edge.
- R5: While the acknowledge output is high, the cycle-start permit is low whatever the core requests.
- R6: After the request goes low, the acknowledge output falls on the third rising edge, which is the first edge at which the synchronized request is seen low.
- R7: After the acknowledge output falls, the float enable stays high for as long as the core request is low. When the core request is high, the permit is still low in that cycle, and the bus is driven again from the next edge.
- R8: At an edge where a synchronized hold request meets a cycle boundary, hold wins over a pending core request, and the permit is low in that cycle.
- R9: While the controller owns the bus and no grant is pending, the permit equals the core request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req_i | input | 1 | Hold request from the external master, asynchronous |
| tstate_i | input | 3 | Current bus state from the sequencer (T1=0, T2=1, T3=2, T4=3, idle=4, wait=5) |
| core_req_i | input | 1 | Core wants to run a bus cycle |
| hlda_o | output | 1 | Hold acknowledge |
| bus_float_o | output | 1 | Tri-state enable for address, data and control drivers |
| cycle_start_ok_o | output | 1 | Sequencer may begin a bus cycle |

## Verification
The bench holds a request through T1, T2, T3 and wait states and expects no grant until a T4 edge. A design that ignored the cycle boundary would float the bus in the middle of a transfer. It measures the edge at which acknowledge rises and falls relative to the request. A missing or extra synchronizer stage would shift that edge by one cycle. It raises a core request in the same cycle as a pending grant, and again while the bus is held and just after release. A design with the wrong priority, or one that resumed driving as soon as acknowledge fell, would show a permit or a dropped float enable one cycle too early.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;
  localparam int TSTATE_W = 3;

  typedef enum logic [TSTATE_W-1:0] {
    TS_T1   = 3'd0,
    TS_T2   = 3'd1,
    TS_T3   = 3'd2,
    TS_T4   = 3'd3,
    TS_IDLE = 3'd4,
    TS_WAIT = 3'd5
  } tstate_e;

  typedef enum logic [1:0] {
    OWN_BUS  = 2'd0,
    HELD_BUS = 2'd1,
    RELEASED = 2'd2
  } own_e;

  // A bus cycle boundary is the end of T4 or any idle state.
  function automatic logic is_cycle_boundary(input logic [TSTATE_W-1:0] ts);
    return (ts == TS_T4) || (ts == TS_IDLE);
  endfunction
endpackage

// File: rtl/bus_hold_sync.sv
module bus_hold_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[LAST];
endmodule

// File: rtl/bus_hold_fsm.sv
module bus_hold_fsm
  import bus_hold_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hold_s_i,
  input  logic [TSTATE_W-1:0] tstate_i,
  input  logic                core_req_i,
  output logic                hlda_o,
  output logic                bus_float_o,
  output logic                start_ok_o
);
  own_e state_q, state_d;

  logic at_boundary;
  logic grant_now;
  logic release_now;
  logic resume_now;

  assign at_boundary = is_cycle_boundary(tstate_i);
  assign grant_now   = hold_s_i && at_boundary && (state_q != HELD_BUS);
  assign release_now = (state_q == HELD_BUS) && !hold_s_i;
  assign resume_now  = (state_q == RELEASED) && core_req_i && !grant_now;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      OWN_BUS:  if (grant_now) state_d = HELD_BUS;
      HELD_BUS: if (release_now) state_d = RELEASED;
      RELEASED: begin
        if (grant_now)       state_d = HELD_BUS;
        else if (resume_now) state_d = OWN_BUS;
      end
      default:  state_d = OWN_BUS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= OWN_BUS;
    else        state_q <= state_d;
  end

  assign hlda_o      = (state_q == HELD_BUS);
  assign bus_float_o = (state_q != OWN_BUS);
  assign start_ok_o  = (state_q == OWN_BUS) && core_req_i && !grant_now;

  // R3
  grant_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda_o) |-> ($past(tstate_i) == TS_T4 || $past(tstate_i) == TS_IDLE));
  // R4
  float_with_hlda_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hlda_o |-> bus_float_o);
  // R5
  no_start_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hlda_o |-> !start_ok_o);
  // R6
  drop_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hlda_o) |-> !$past(hold_s_i));
  // R7
  drive_on_demand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_float_o) |-> $past(core_req_i));
  // R2
  grant_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda_o) |-> $past(hold_s_i));
endmodule

// File: rtl/bus_hold_arb.sv
module bus_hold_arb
  import bus_hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hold_req_i,
  input  logic [TSTATE_W-1:0] tstate_i,
  input  logic                core_req_i,
  output logic                hlda_o,
  output logic                bus_float_o,
  output logic                cycle_start_ok_o
);
  logic hold_sync;

  bus_hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (hold_req_i),
    .sync_o  (hold_sync)
  );

  bus_hold_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_s_i    (hold_sync),
    .tstate_i    (tstate_i),
    .core_req_i  (core_req_i),
    .hlda_o      (hlda_o),
    .bus_float_o (bus_float_o),
    .start_ok_o  (cycle_start_ok_o)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!hlda_o && !bus_float_o));
endmodule

// File: tb/bus_hold_arb_tb_top.sv
module bus_hold_arb_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hold_req = 1'b0;
  logic [2:0] tstate = 3'd4;
  logic       core_req = 1'b0;
  logic       hlda, bfloat, permit;

  localparam logic [2:0] T1 = 3'd0, T2 = 3'd1, T3 = 3'd2, T4 = 3'd3, TI = 3'd4, TW = 3'd5;

  typedef struct {
    logic  h;
    logic  f;
    logic  p;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  bus_hold_arb dut_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .hold_req_i       (hold_req),
    .tstate_i         (tstate),
    .core_req_i       (core_req),
    .hlda_o           (hlda),
    .bus_float_o      (bfloat),
    .cycle_start_ok_o (permit)
  );

  // One cycle: drive at negedge, expected outputs for this cycle go to the queue.
  task automatic drive(input logic h, input logic [2:0] ts, input logic rq,
                       input logic eh, input logic ef, input logic ep, input string tag);
    exp_t e;
    @(negedge clk);
    hold_req = h;
    tstate   = ts;
    core_req = rq;
    e.h = eh; e.f = ef; e.p = ep; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compares outputs shortly after each negedge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_checks++;
        if ({hlda, bfloat, permit} !== {e.h, e.f, e.p}) begin
          n_fail++;
          $display("FAIL %s: hlda/float/permit actual %b%b%b expected %b%b%b",
                   e.tag, hlda, bfloat, permit, e.h, e.f, e.p);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    drive(0, TI, 0, 0, 0, 0, "R1 in reset");
    drive(0, TI, 0, 0, 0, 0, "R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    drive(0, TI, 0, 0, 0, 0, "R1 after reset");
    drive(0, TI, 1, 0, 0, 1, "R9 owned permit");
    drive(0, T1, 0, 0, 0, 0, "R9 owned no req");

    // Grant at idle; core request collides with the grant
    drive(1, TI, 1, 0, 0, 1, "R2 sync stage 1");
    drive(1, TI, 1, 0, 0, 1, "R2 sync stage 2");
    drive(1, TI, 1, 0, 0, 0, "R8 hold wins");
    drive(1, TI, 1, 1, 1, 0, "R2 R4 grant edge");
    drive(1, TI, 1, 1, 1, 0, "R5 no start in hold");
    // Release
    drive(0, TI, 1, 1, 1, 0, "R6 hold kept c0");
    drive(0, TI, 1, 1, 1, 0, "R6 hold kept c1");
    drive(0, TI, 1, 1, 1, 0, "R6 hold kept c2");
    drive(0, TI, 1, 0, 1, 0, "R6 R7 released");
    drive(0, TI, 1, 0, 0, 1, "R7 bus driven again");

    // Request during a bus cycle: grant waits for T4
    drive(1, T1, 0, 0, 0, 0, "R3 T1");
    drive(1, T2, 0, 0, 0, 0, "R3 T2");
    drive(1, T3, 0, 0, 0, 0, "R3 T3");
    drive(1, TW, 0, 0, 0, 0, "R3 after T3");
    drive(1, TW, 0, 0, 0, 0, "R3 after wait");
    drive(1, T4, 0, 0, 0, 0, "R3 after wait 2");
    drive(1, T1, 0, 1, 1, 0, "R3 R4 grant after T4");
    drive(0, TI, 0, 1, 1, 0, "R6 c0");
    drive(0, TI, 0, 1, 1, 0, "R6 c1");
    drive(0, TI, 0, 1, 1, 0, "R6 c2");
    drive(0, TI, 0, 0, 1, 0, "R6 fall");
    drive(0, TI, 0, 0, 1, 0, "R7 stays floated");
    drive(0, TI, 0, 0, 1, 0, "R7 stays floated 2");
    drive(0, TI, 1, 0, 1, 0, "R7 request seen");
    drive(0, TI, 1, 0, 0, 1, "R7 driven");
    drive(0, TI, 0, 0, 0, 0, "R9 idle");

    @(negedge clk);
    @(negedge clk);
    #2;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule